// File: doc/BRIEF.md
# Debug Access Authorization Controller

This block decides, for a two-core system, which debug features are open to an external debugger. It takes several inputs. Two one-time-programmed disable flags close either all debug or only secure debug. Two enrollment bits mark which of two stored 128-bit debug keys are active. Key words arrive from the debug link on a valid/ready stream. A software override register can reopen features that the flags or keys have closed. Each core also has an architecture-select bit, which is sampled when that core takes a warm reset.

From these inputs it drives five registered enables:
- one memory access port per core;
- secure access and secure debug, one per core;
- one enable shared by the other debug components, which are the cross-trigger unit and the access port to the alternate-architecture debug module.

The two keys give different levels of privilege. Enrollment slot 0 (key index 5) holds the secure key. Slot 1 (key index 6) holds the non-secure key. A correct key sets a sticky unlock flag, and only a cold reset clears it. The key input stream never applies back-pressure. Once reset is released, `key_ready` stays high and every beat with `key_valid` high is compared in the cycle it is presented.

Top module: `dbg_auth_ctrl`

## Requirements
- R1: While `rst_n` is low, all five enables and `key_ready` are 0, the override register is cleared to zero and both unlock flags are cleared.
- R2: When `otp_all_dis` is 1, each of the five features is off unless its own override bit is 1. Override bit layout: [0] core0 access port, [1] core0 secure, [2] core1 access port, [3] core1 secure, [4] misc components.
- R3: When `otp_sec_dis` is 1 and no other restriction applies, both access ports and misc stay on and both secure enables are off. Setting override bits [1] and [3] reopens secure debug.
- R4: With exactly one key enrolled (`key_enroll` = 01 or 10), all features are off until that key's exact value is accepted. After that, all features are on.
- R5: With both keys enrolled (`key_enroll` = 11): no key accepted means all features are off. Accepting the non-secure key (slot 1) turns on the access ports and misc, but not secure. Accepting the secure key (slot 0) lifts every key restriction.
- R6: The OTP flags keep applying after any key unlock. For example, `otp_all_dis` with the secure key accepted still closes all features unless override bits are set.
- R7: An unlock flag is set only when a 128-bit key word equals an enrolled key exactly. A word that differs in any bit, or that matches a key that is not enrolled, unlocks nothing. A flag that is already set is never cleared by a later mismatch.
- R8: A core's secure enable is 1 only if that core's access-port enable is also 1, whatever the override bits are.
- R9: A pulse on `core_wrst[i]` while `arch_sel[i]` is 1 forces core i's access port, and with it core i's secure enable, off. The override register cannot turn them back on. A later pulse with `arch_sel[i]` at 0 removes the gate.
- R10: The override register loads `ovr_wdata` on a cycle with `ovr_we` high. Changes on `ovr_wdata` with `ovr_we` low have no effect.
- R11: All enables are registered. A change to a flag, to the override register or to an unlock flag shows up at the outputs on the next clock edge.
- R12: From the first clock edge after reset is released, `key_ready` is 1 and stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Cold reset, active low |
| otp_all_dis | input | 1 | OTP flag that closes all debug |
| otp_sec_dis | input | 1 | OTP flag that closes secure debug |
| key_enroll | input | 2 | Enrolled bits: [0] secure key, [1] non-secure key |
| key_sec_ref | input | 128 | Stored secure key value |
| key_ns_ref | input | 128 | Stored non-secure key value |
| key_valid | input | 1 | Key word present on the debug link |
| key_ready | output | 1 | Key word accepted (high after reset) |
| key_data | input | 128 | Supplied key word |
| ovr_we | input | 1 | Override register write enable |
| ovr_wdata | input | 5 | Override register write data |
| arch_sel | input | 2 | Per-core alternate-architecture select |
| core_wrst | input | 2 | Per-core warm reset pulse |
| core_ap_en | output | 2 | Per-core memory access port enable |
| core_sec_en | output | 2 | Per-core secure access and secure debug enable |
| misc_en | output | 1 | Cross-trigger and debug-module access port enable |

## Verification
A table walks the combinations of the two OTP flags, the four enrollment patterns and the key supplied (none, the secure key, the non-secure key). Each combination is tried with override values of zero, all ones, only the access-port bits and only the secure bits. The all-zero override separates full, secure-only and no restriction from one another. The partial overrides show which restriction each flag or key imposes, and confirm that a secure bit without its access-port bit stays off. Directed tests then cover:
- a key that is wrong in a single bit;
- a mismatch after an unlock;
- a write attempt with the write enable low;
- the architecture gate set and then cleared again by warm resets.

// File: rtl/dbg_auth_pkg.sv
package dbg_auth_pkg;
  // combined restriction before overrides
  typedef struct packed {
    logic all_off;
    logic sec_off;
  } restrict_t;

  localparam int unsigned SLOT_SEC = 0;
  localparam int unsigned SLOT_NS  = 1;
endpackage

// File: rtl/dbg_key_unlock.sv
module dbg_key_unlock #(
  parameter int unsigned KEY_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       enroll,
  input  logic [KEY_W-1:0] ref_sec,
  input  logic [KEY_W-1:0] ref_ns,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [KEY_W-1:0] in_data,
  output logic [1:0]       unlocked
);
  import dbg_auth_pkg::*;

  logic            rdy_q;
  logic [1:0]      unl_q;
  logic [1:0]      hit;
  logic [KEY_W-1:0] refs [2];

  assign refs[SLOT_SEC] = ref_sec;
  assign refs[SLOT_NS]  = ref_ns;

  for (genvar s = 0; s < 2; s++) begin : g_cmp
    assign hit[s] = enroll[s] && (in_data == refs[s]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= 1'b0;
      unl_q <= '0;
    end else begin
      rdy_q <= 1'b1;
      if (in_valid && rdy_q) unl_q <= unl_q | hit;
    end
  end

  assign in_ready = rdy_q;
  assign unlocked = unl_q;
endmodule

// File: rtl/dbg_arch_gate.sv
module dbg_arch_gate #(
  parameter int unsigned NCORE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCORE-1:0] arch_sel,
  input  logic [NCORE-1:0] wrst,
  output logic [NCORE-1:0] blocked
);
  logic [NCORE-1:0] blk_q;

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       blk_q[c] <= 1'b0;
      else if (wrst[c]) blk_q[c] <= arch_sel[c];
    end
  end

  assign blocked = blk_q;
endmodule

// File: rtl/dbg_policy.sv
module dbg_policy #(
  parameter int unsigned NCORE = 2,
  localparam int unsigned OVR_W = 2*NCORE + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             otp_all_dis,
  input  logic             otp_sec_dis,
  input  logic [1:0]       enroll,
  input  logic [1:0]       unlocked,
  input  logic [OVR_W-1:0] ovr,
  input  logic [NCORE-1:0] blocked,
  output logic [NCORE-1:0] ap_en,
  output logic [NCORE-1:0] sec_en,
  output logic             misc_en
);
  import dbg_auth_pkg::*;

  restrict_t        rs;
  logic             any_enr, top_ok, low_ok;
  logic [NCORE-1:0] ap_d, sec_d;
  logic             misc_d;

  always_comb begin
    any_enr = |enroll;
    // most secure enrolled key satisfied
    top_ok  = enroll[SLOT_SEC] ? unlocked[SLOT_SEC] : unlocked[SLOT_NS];
    // any enrolled key satisfied
    low_ok  = |unlocked;
    rs.all_off = otp_all_dis | (any_enr & ~low_ok);
    rs.sec_off = otp_sec_dis | rs.all_off | (any_enr & ~top_ok);
  end

  for (genvar c = 0; c < NCORE; c++) begin : g_feat
    assign ap_d[c]  = (~rs.all_off | ovr[2*c]) & ~blocked[c];
    assign sec_d[c] = (~rs.sec_off | ovr[2*c+1]) & ap_d[c];
  end
  assign misc_d = ~rs.all_off | ovr[OVR_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ap_en   <= '0;
      sec_en  <= '0;
      misc_en <= 1'b0;
    end else begin
      ap_en   <= ap_d;
      sec_en  <= sec_d;
      misc_en <= misc_d;
    end
  end
endmodule

// File: rtl/dbg_auth_ctrl.sv
module dbg_auth_ctrl #(
  parameter int unsigned NCORE = 2,
  parameter int unsigned KEY_W = 128,
  localparam int unsigned OVR_W = 2*NCORE + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             otp_all_dis,
  input  logic             otp_sec_dis,
  input  logic [1:0]       key_enroll,
  input  logic [KEY_W-1:0] key_sec_ref,
  input  logic [KEY_W-1:0] key_ns_ref,
  input  logic             key_valid,
  output logic             key_ready,
  input  logic [KEY_W-1:0] key_data,
  input  logic             ovr_we,
  input  logic [OVR_W-1:0] ovr_wdata,
  input  logic [NCORE-1:0] arch_sel,
  input  logic [NCORE-1:0] core_wrst,
  output logic [NCORE-1:0] core_ap_en,
  output logic [NCORE-1:0] core_sec_en,
  output logic             misc_en
);
  logic [OVR_W-1:0] ovr_q;
  logic [1:0]       unl_flags;
  logic [NCORE-1:0] arch_blk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ovr_q <= '0;
    else if (ovr_we) ovr_q <= ovr_wdata;
  end

  dbg_key_unlock #(.KEY_W(KEY_W)) u_keys (
    .clk(clk), .rst_n(rst_n), .enroll(key_enroll),
    .ref_sec(key_sec_ref), .ref_ns(key_ns_ref),
    .in_valid(key_valid), .in_ready(key_ready), .in_data(key_data),
    .unlocked(unl_flags)
  );

  dbg_arch_gate #(.NCORE(NCORE)) u_gate (
    .clk(clk), .rst_n(rst_n), .arch_sel(arch_sel), .wrst(core_wrst),
    .blocked(arch_blk)
  );

  dbg_policy #(.NCORE(NCORE)) u_pol (
    .clk(clk), .rst_n(rst_n), .otp_all_dis(otp_all_dis),
    .otp_sec_dis(otp_sec_dis), .enroll(key_enroll), .unlocked(unl_flags),
    .ovr(ovr_q), .blocked(arch_blk), .ap_en(core_ap_en),
    .sec_en(core_sec_en), .misc_en(misc_en)
  );
endmodule

// File: rtl/dbg_auth_chk.sv
module dbg_auth_chk #(
  parameter int unsigned NCORE = 2,
  localparam int unsigned OVR_W = 2*NCORE + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             otp_all_dis,
  input logic             otp_sec_dis,
  input logic             key_ready,
  input logic [OVR_W-1:0] ovr_q,
  input logic [1:0]       unl_flags,
  input logic [NCORE-1:0] arch_sel,
  input logic [NCORE-1:0] core_wrst,
  input logic [NCORE-1:0] core_ap_en,
  input logic [NCORE-1:0] core_sec_en,
  input logic             misc_en
);
  for (genvar c = 0; c < NCORE; c++) begin : g_c
    // R8
    sec_needs_ap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      core_sec_en[c] |-> core_ap_en[c]);
    // R9
    arch_gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (core_wrst[c] && arch_sel[c]) |-> ##2 !core_ap_en[c]);
  end

  // R7
  unlock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |unl_flags |=> ((unl_flags & $past(unl_flags)) == $past(unl_flags)));
  // R12
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_ready |=> key_ready);
  // R2
  all_dis_misc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (otp_all_dis && !ovr_q[OVR_W-1]) |=> !misc_en);
  // R3
  sec_dis_core0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (otp_sec_dis && !ovr_q[1]) |=> !core_sec_en[0]);
endmodule

bind dbg_auth_ctrl dbg_auth_chk #(.NCORE(NCORE)) u_chk (
  .clk(clk), .rst_n(rst_n), .otp_all_dis(otp_all_dis),
  .otp_sec_dis(otp_sec_dis), .key_ready(key_ready), .ovr_q(ovr_q),
  .unl_flags(unl_flags), .arch_sel(arch_sel), .core_wrst(core_wrst),
  .core_ap_en(core_ap_en), .core_sec_en(core_sec_en), .misc_en(misc_en)
);

// File: tb/test_dbg_auth_ctrl.sv
module test_dbg_auth_ctrl;
  localparam logic [127:0] SKEY = 128'h0123_4567_89ab_cdef_f0e1_d2c3_b4a5_9687;
  localparam logic [127:0] NKEY = 128'hdead_beef_5a5a_a5a5_1357_9bdf_2468_ace0;
  // [15] all_dis [14] sec_dis [13:12] enroll {ns,s} [11] give sec key
  // [10] give ns key [9:5] override [4:0] expected {misc,sec1,ap1,sec0,ap0}
  localparam int NV = 18;
  localparam logic [15:0] VEC [NV] = '{
    {1'b0,1'b0,2'b00,1'b0,1'b0,5'b00000,5'b11111},
    {1'b1,1'b0,2'b00,1'b0,1'b0,5'b00000,5'b00000},
    {1'b1,1'b0,2'b00,1'b0,1'b0,5'b11111,5'b11111},
    {1'b1,1'b0,2'b00,1'b0,1'b0,5'b10101,5'b10101},
    {1'b0,1'b1,2'b00,1'b0,1'b0,5'b00000,5'b10101},
    {1'b0,1'b1,2'b00,1'b0,1'b0,5'b01010,5'b11111},
    {1'b0,1'b0,2'b01,1'b0,1'b0,5'b00000,5'b00000},
    {1'b0,1'b0,2'b01,1'b1,1'b0,5'b00000,5'b11111},
    {1'b0,1'b0,2'b10,1'b0,1'b1,5'b00000,5'b11111},
    {1'b0,1'b0,2'b10,1'b1,1'b0,5'b00000,5'b00000},
    {1'b0,1'b0,2'b11,1'b0,1'b1,5'b00000,5'b10101},
    {1'b0,1'b0,2'b11,1'b1,1'b0,5'b00000,5'b11111},
    {1'b0,1'b0,2'b11,1'b0,1'b0,5'b00000,5'b00000},
    {1'b0,1'b0,2'b11,1'b0,1'b1,5'b01010,5'b11111},
    {1'b1,1'b0,2'b11,1'b1,1'b0,5'b00000,5'b00000},
    {1'b0,1'b0,2'b11,1'b0,1'b0,5'b00010,5'b00000},
    {1'b0,1'b0,2'b01,1'b0,1'b0,5'b11111,5'b11111},
    {1'b0,1'b1,2'b11,1'b1,1'b0,5'b00000,5'b10101}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         otp_all_dis = 1'b0, otp_sec_dis = 1'b0;
  logic [1:0]   key_enroll = 2'b00;
  logic         key_valid = 1'b0;
  logic         key_ready;
  logic [127:0] key_data = '0;
  logic         ovr_we = 1'b0;
  logic [4:0]   ovr_wdata = '0;
  logic [1:0]   arch_sel = '0, core_wrst = '0;
  logic [1:0]   core_ap_en, core_sec_en;
  logic         misc_en;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dbg_auth_ctrl i_dbg_auth_ctrl (
    .clk(clk), .rst_n(rst_n), .otp_all_dis(otp_all_dis),
    .otp_sec_dis(otp_sec_dis), .key_enroll(key_enroll),
    .key_sec_ref(SKEY), .key_ns_ref(NKEY), .key_valid(key_valid),
    .key_ready(key_ready), .key_data(key_data), .ovr_we(ovr_we),
    .ovr_wdata(ovr_wdata), .arch_sel(arch_sel), .core_wrst(core_wrst),
    .core_ap_en(core_ap_en), .core_sec_en(core_sec_en), .misc_en(misc_en)
  );

  function automatic logic [4:0] outs();
    return {misc_en, core_sec_en[1], core_ap_en[1], core_sec_en[0], core_ap_en[0]};
  endfunction

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cold_reset();
    rst_n = 1'b0; key_valid = 1'b0; ovr_we = 1'b0; core_wrst = '0;
    cyc(2);
    rst_n = 1'b1;
    cyc(1);
  endtask

  task automatic send_key(input logic [127:0] k);
    key_data = k; key_valid = 1'b1;
    cyc(1);
    key_valid = 1'b0;
  endtask

  task automatic write_ovr(input logic [4:0] v);
    ovr_wdata = v; ovr_we = 1'b1;
    cyc(1);
    ovr_we = 1'b0;
  endtask

  task automatic warm(input int c, input logic sel);
    arch_sel[c] = sel; core_wrst[c] = 1'b1;
    cyc(1);
    core_wrst[c] = 1'b0;
  endtask

  initial begin
    cyc(1);
    // R1: state held in reset
    check("R1 outputs in reset", outs(), 5'b00000);
    check("R1 key_ready in reset", {4'b0, key_ready}, 5'b00000);
    rst_n = 1'b1;
    cyc(1);
    // R12
    check("R12 key_ready after reset", {4'b0, key_ready}, 5'b00001);

    // table walk: R2 R3 R4 R5 R6 R8 R10
    for (int i = 0; i < NV; i++) begin
      otp_all_dis = VEC[i][15];
      otp_sec_dis = VEC[i][14];
      key_enroll  = VEC[i][13:12];
      cold_reset();
      if (VEC[i][11]) send_key(SKEY);
      if (VEC[i][10]) send_key(NKEY);
      write_ovr(VEC[i][9:5]);
      cyc(2);
      check($sformatf("R2/R3/R4/R5/R6/R8 vector %0d", i), outs(), VEC[i][4:0]);
    end

    // R7: single-bit miss, then unlock, then mismatch keeps flag
    otp_all_dis = 1'b0; otp_sec_dis = 1'b0; key_enroll = 2'b01;
    cold_reset();
    send_key(SKEY ^ 128'h1);
    cyc(2);
    check("R7 near-miss key", outs(), 5'b00000);
    send_key(SKEY);
    cyc(2);
    check("R7 exact key unlocks", outs(), 5'b11111);
    send_key(NKEY);
    cyc(2);
    check("R7 mismatch keeps unlock", outs(), 5'b11111);

    // R1: override register back to zero after cold reset
    otp_all_dis = 1'b1; key_enroll = 2'b00;
    write_ovr(5'b11111);
    cold_reset();
    cyc(1);
    check("R1 override cleared", outs(), 5'b00000);

    // R10: data without write enable ignored
    ovr_wdata = 5'b11111;
    cyc(3);
    check("R10 no write without enable", outs(), 5'b00000);

    // R11: output latency of one edge after override write
    ovr_wdata = 5'b10000; ovr_we = 1'b1;
    cyc(1);
    ovr_we = 1'b0;
    check("R11 not yet visible", outs(), 5'b00000);
    cyc(1);
    check("R11 visible next edge", outs(), 5'b10000);

    // R9: arch gate on core1, override cannot restore
    otp_all_dis = 1'b0;
    write_ovr(5'b11111);
    warm(1, 1'b1);
    cyc(2);
    check("R9 core1 gated", outs(), 5'b10011);
    warm(1, 1'b0);
    cyc(2);
    check("R9 gate cleared", outs(), 5'b11111);
    warm(0, 1'b1);
    arch_sel = '0;
    cyc(2);
    check("R9 core0 gated", outs(), 5'b11100);
    check("R12 key_ready held", {4'b0, key_ready}, 5'b00001);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule